// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits between a request source and a 32-bit parallel NOR flash array. The array is built from two 16-bit devices wired side by side, so each command byte is sent as the same 16-bit value into both halves of the bus word. A requester asks for one of three operations. It can program a single 32-bit word, erase the block that contains an address, or probe the device identifiers. The sequencer then issues every command write and status read on a simple synchronous bus and reports one pass or fail result.

Each operation ends with a write of the read-array command, so the flash is back in plain read mode when the result appears. Programming is only called good if both status halves show no program error and a read-back of the target word matches the data written. The status loop is bounded by a poll limit taken with the request. When the limit is used up, the flash is put back in read-array mode and the result is a timeout failure.

Top module: `flashOpSeq`

## Requirements
- R1: After reset, `busy`, `done`, `busWe` and `busRe` are all low, and no bus strobe occurs until a request is accepted.
- R2: A program request (`reqOp` = 0) writes 0x00400040 to the target address and then writes the request data word to that same address.
- R3: An erase request (`reqOp` = 1) writes 0x00200020 and then 0x00D000D0, both to the target address.
- R4: After R2 or R3, the block repeats a pair of bus operations: a write of 0x00700070 to the target, then a read of the target. It stops once the returned word has bit 7 and bit 23 both set. If only one of those bits is set, polling goes on.
- R5: Every operation, including a timed-out one, writes 0x00FF00FF before `done`. The address is the target for program and erase, and 0 for an identifier probe.
- R6: An erase fails when the last status word has bit 5 or bit 21 set. The program-error bits (4 and 20) have no effect on an erase result.
- R7: A program fails when the last status word has bit 4 or bit 20 set. After the R5 write, exactly one read of the target is made, and the program also fails if that word differs from the request data.
- R8: An identifier request (`reqOp` = 2) writes 0x00900090 to address 0 and reads address 0, then address 1. It passes only if the first word is 0x00890089 and the second is 0x88F388F3 or 0x88F488F4.
- R9: If the status read numbered `pollLimit` still shows not-ready, polling stops. A limit of 0 allows one read. The R5 write follows with no verify read, and `done` comes with `pass` = 0 and `timedOut` = 1.
- R10: `busy` rises in the cycle after an accepted request. It stays high through the single-cycle `done` and falls in the next cycle. Requests that arrive while busy are ignored, and `reqOp` = 3 is never accepted.
- R11: At most one strobe is high in any cycle and each strobe lasts one cycle. After a read strobe, no strobe is issued until `busRvalid` has returned the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqOp | input | 2 | 0 program, 1 erase, 2 identify, 3 none |
| reqAddr | input | ADDR_W | Target word address |
| reqData | input | 32 | Word to program |
| pollLimit | input | POLL_W | Maximum number of status reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| timedOut | output | 1 | Poll limit reached, valid with done |
| busAddr | output | ADDR_W | Flash bus address |
| busWdata | output | 32 | Flash bus write data |
| busWe | output | 1 | Flash write strobe |
| busRe | output | 1 | Flash read strobe |
| busRdata | input | 32 | Flash read data |
| busRvalid | input | 1 | Read data valid |

## Verification
The hardest cases to reach from the ports are status words where only one half reports ready, and status loops that never finish. The bench's flash model has settings for these. It can return a fixed number of not-ready words, set the ready bit in only one half, or never become ready at all, which drives the poll limit down to a single read. The same model can corrupt the stored word on a program. This makes a read-back mismatch appear even though the status shows no error. Each expected bus transaction is queued from the requirements and matched against the bus on the cycle it occurs.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  localparam int HALF_W     = 16;
  localparam int NUM_HALVES = 2;
  localparam int DATA_W     = HALF_W * NUM_HALVES;

  // status bit positions inside each half
  localparam int RDY_BIT  = 7;
  localparam int EERR_BIT = 5;
  localparam int PERR_BIT = 4;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_IDENT = 2'd2,
    OP_NONE  = 2'd3
  } opKind_t;

  typedef enum logic [2:0] {
    W_RDARRAY,
    W_READID,
    W_ESETUP,
    W_ECONF,
    W_PSETUP,
    W_RDSTAT,
    W_DATA
  } wrSel_t;

  typedef enum logic [1:0] {
    A_TARGET,
    A_ZERO,
    A_ONE
  } addrSel_t;

  typedef struct packed {
    logic     we;
    logic     re;
    wrSel_t   wrSel;
    addrSel_t addrSel;
    logic     loadReq;
    logic     capStatus;
    logic     capId0;
    logic     capId1;
    logic     capVerify;
    logic     clrPoll;
    logic     incPoll;
    logic     setTimeout;
  } seqCtl_t;

  function automatic logic [DATA_W-1:0] dupByte(input logic [7:0] b);
    logic [HALF_W-1:0] h;
    h = {{(HALF_W-8){1'b0}}, b};
    return {NUM_HALVES{h}};
  endfunction

  localparam logic [DATA_W-1:0] CMD_RDARRAY = dupByte(8'hFF);
  localparam logic [DATA_W-1:0] CMD_READID  = dupByte(8'h90);
  localparam logic [DATA_W-1:0] CMD_ESETUP  = dupByte(8'h20);
  localparam logic [DATA_W-1:0] CMD_ECONF   = dupByte(8'hD0);
  localparam logic [DATA_W-1:0] CMD_PSETUP  = dupByte(8'h40);
  localparam logic [DATA_W-1:0] CMD_RDSTAT  = dupByte(8'h70);

  localparam logic [DATA_W-1:0] ID_MFR     = dupByte(8'h89);
  localparam logic [DATA_W-1:0] ID_DEV_TOP = {NUM_HALVES{16'h88F3}};
  localparam logic [DATA_W-1:0] ID_DEV_BOT = {NUM_HALVES{16'h88F4}};

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       busRvalid,
  input  logic       statusReadyNow,
  input  logic       pollExhausted,
  input  opKind_t    curOp,
  input  logic       timedOutReg,
  output seqCtl_t    ctl,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_SECOND, S_PCMD, S_PRD, S_PWT,
    S_I0RD, S_I0WT, S_I1RD, S_I1WT, S_RESTORE, S_VRD, S_VWT, S_DONE
  } state_t;

  state_t state, nextState;
  logic isIdent, isProg;

  assign isIdent = (curOp == OP_IDENT);
  assign isProg  = (curOp == OP_PROG);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl         = '0;
    ctl.wrSel   = W_RDARRAY;
    ctl.addrSel = A_TARGET;
    nextState   = state;
    case (state)
      S_IDLE: begin
        if (reqValid && opKind_t'(reqOp) != OP_NONE) begin
          ctl.loadReq = 1'b1;
          ctl.clrPoll = 1'b1;
          nextState   = S_SETUP;
        end
      end
      S_SETUP: begin
        ctl.we = 1'b1;
        if (isIdent) begin
          ctl.wrSel   = W_READID;
          ctl.addrSel = A_ZERO;
          nextState   = S_I0RD;
        end else begin
          ctl.wrSel = isProg ? W_PSETUP : W_ESETUP;
          nextState = S_SECOND;
        end
      end
      S_SECOND: begin
        ctl.we    = 1'b1;
        ctl.wrSel = isProg ? W_DATA : W_ECONF;
        nextState = S_PCMD;
      end
      S_PCMD: begin
        ctl.we    = 1'b1;
        ctl.wrSel = W_RDSTAT;
        nextState = S_PRD;
      end
      S_PRD: begin
        ctl.re    = 1'b1;
        nextState = S_PWT;
      end
      S_PWT: begin
        if (busRvalid) begin
          ctl.capStatus = 1'b1;
          ctl.incPoll   = 1'b1;
          if (statusReadyNow) begin
            nextState = S_RESTORE;
          end else if (pollExhausted) begin
            ctl.setTimeout = 1'b1;
            nextState      = S_RESTORE;
          end else begin
            nextState = S_PCMD;
          end
        end
      end
      S_I0RD: begin
        ctl.re      = 1'b1;
        ctl.addrSel = A_ZERO;
        nextState   = S_I0WT;
      end
      S_I0WT: begin
        if (busRvalid) begin
          ctl.capId0 = 1'b1;
          nextState  = S_I1RD;
        end
      end
      S_I1RD: begin
        ctl.re      = 1'b1;
        ctl.addrSel = A_ONE;
        nextState   = S_I1WT;
      end
      S_I1WT: begin
        if (busRvalid) begin
          ctl.capId1 = 1'b1;
          nextState  = S_RESTORE;
        end
      end
      S_RESTORE: begin
        ctl.we      = 1'b1;
        ctl.wrSel   = W_RDARRAY;
        ctl.addrSel = isIdent ? A_ZERO : A_TARGET;
        nextState   = (isProg && !timedOutReg) ? S_VRD : S_DONE;
      end
      S_VRD: begin
        ctl.re    = 1'b1;
        nextState = S_VWT;
      end
      S_VWT: begin
        if (busRvalid) begin
          ctl.capVerify = 1'b1;
          nextState     = S_DONE;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/flashSeqPath.sv
module flashSeqPath
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [DATA_W-1:0] busRdata,
  output opKind_t           curOp,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWe,
  output logic              busRe,
  output logic              statusReadyNow,
  output logic              pollExhausted,
  output logic              resultOk,
  output logic              timedOutReg
);

  localparam int CNT_W = POLL_W + 1;

  opKind_t           opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [POLL_W-1:0] limitReg;
  logic [POLL_W-1:0] pollCnt;
  logic [DATA_W-1:0] statusReg;
  logic [DATA_W-1:0] id0Reg;
  logic [DATA_W-1:0] id1Reg;
  logic              verMatch;

  logic [NUM_HALVES-1:0] halfReady;
  logic [NUM_HALVES-1:0] halfPgmErr;
  logic [NUM_HALVES-1:0] halfEraseErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg       <= OP_PROG;
      addrReg     <= '0;
      dataReg     <= '0;
      limitReg    <= '0;
      pollCnt     <= '0;
      statusReg   <= '0;
      id0Reg      <= '0;
      id1Reg      <= '0;
      verMatch    <= 1'b0;
      timedOutReg <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        opReg    <= opKind_t'(reqOp);
        addrReg  <= reqAddr;
        dataReg  <= reqData;
        limitReg <= pollLimit;
      end
      if (ctl.clrPoll) begin
        pollCnt     <= '0;
        timedOutReg <= 1'b0;
        verMatch    <= 1'b0;
      end else if (ctl.incPoll) begin
        pollCnt <= pollCnt + 1'b1;
      end
      if (ctl.setTimeout) timedOutReg <= 1'b1;
      if (ctl.capStatus)  statusReg   <= busRdata;
      if (ctl.capId0)     id0Reg      <= busRdata;
      if (ctl.capId1)     id1Reg      <= busRdata;
      if (ctl.capVerify)  verMatch    <= (busRdata == dataReg);
    end
  end

  // per-half status decode
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign halfReady[h]    = busRdata[h*HALF_W + RDY_BIT];
    assign halfPgmErr[h]   = statusReg[h*HALF_W + PERR_BIT];
    assign halfEraseErr[h] = statusReg[h*HALF_W + EERR_BIT];
  end

  assign statusReadyNow = &halfReady;
  assign pollExhausted  = (CNT_W'(pollCnt) + CNT_W'(1)) >= CNT_W'(limitReg);

  always_comb begin
    resultOk = 1'b0;
    if (!timedOutReg) begin
      case (opReg)
        OP_PROG:  resultOk = !(|halfPgmErr) && verMatch;
        OP_ERASE: resultOk = !(|halfEraseErr);
        OP_IDENT: resultOk = (id0Reg == ID_MFR) &&
                             ((id1Reg == ID_DEV_TOP) || (id1Reg == ID_DEV_BOT));
        default:  resultOk = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (ctl.addrSel)
      A_ZERO:  busAddr = '0;
      A_ONE:   busAddr = ADDR_W'(1);
      default: busAddr = addrReg;
    endcase
  end

  always_comb begin
    case (ctl.wrSel)
      W_READID: busWdata = CMD_READID;
      W_ESETUP: busWdata = CMD_ESETUP;
      W_ECONF:  busWdata = CMD_ECONF;
      W_PSETUP: busWdata = CMD_PSETUP;
      W_RDSTAT: busWdata = CMD_RDSTAT;
      W_DATA:   busWdata = dataReg;
      default:  busWdata = CMD_RDARRAY;
    endcase
  end

  assign busWe = ctl.we;
  assign busRe = ctl.re;
  assign curOp = opReg;

endmodule

// File: rtl/flashOpSeq.sv
module flashOpSeq
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              timedOut,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic              busWe,
  output logic              busRe,
  input  logic [31:0]       busRdata,
  input  logic              busRvalid
);

  seqCtl_t ctl;
  opKind_t curOp;
  logic    statusReadyNow;
  logic    pollExhausted;
  logic    resultOk;
  logic    timedOutReg;

  flashSeqCtrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .reqOp          (reqOp),
    .busRvalid      (busRvalid),
    .statusReadyNow (statusReadyNow),
    .pollExhausted  (pollExhausted),
    .curOp          (curOp),
    .timedOutReg    (timedOutReg),
    .ctl            (ctl),
    .busy           (busy),
    .done           (done)
  );

  flashSeqPath #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) uPath (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .reqOp          (reqOp),
    .reqAddr        (reqAddr),
    .reqData        (reqData),
    .pollLimit      (pollLimit),
    .busRdata       (busRdata),
    .curOp          (curOp),
    .busAddr        (busAddr),
    .busWdata       (busWdata),
    .busWe          (busWe),
    .busRe          (busRe),
    .statusReadyNow (statusReadyNow),
    .pollExhausted  (pollExhausted),
    .resultOk       (resultOk),
    .timedOutReg    (timedOutReg)
  );

  assign pass     = done & resultOk;
  assign timedOut = done & timedOutReg;

endmodule

// File: rtl/flashOpSeqChk.sv
module flashOpSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqOp,
  input logic        busy,
  input logic        done,
  input logic        pass,
  input logic        timedOut,
  input logic        busWe,
  input logic        busRe,
  input logic [31:0] busWdata
);

  logic [31:0] lastWr;

  always_ff @(posedge clk) begin
    if (!rstN)      lastWr <= '0;
    else if (busWe) lastWr <= busWdata;
  end

  // R1: no strobes while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWe && !busRe));

  // R5: last write before done restores read-array mode
  a_r5_restore_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lastWr == 32'h00FF00FF));

  // R9: a timeout never reports a pass
  a_r9_timeout_fails: assert property (@(posedge clk) disable iff (!rstN)
    (done && timedOut) |-> !pass);

  // R10: accepted request raises busy
  a_r10_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqOp != 2'd3) |=> busy);

  // R10: done is a single cycle, inside busy, followed by idle
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R11: strobes are exclusive and one cycle long
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));
  a_r11_re_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> !busRe);

endmodule

bind flashOpSeq flashOpSeqChk chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .timedOut (timedOut),
  .busWe    (busWe),
  .busRe    (busRe),
  .busWdata (busWdata)
);

// File: tb/flashOpSeq_test.sv
module flashOpSeq_test;

  localparam int AW = 22;
  localparam int PW = 16;
  localparam logic [31:0] C_RA = 32'h00FF00FF;
  localparam logic [31:0] C_ID = 32'h00900090;
  localparam logic [31:0] C_ES = 32'h00200020;
  localparam logic [31:0] C_EC = 32'h00D000D0;
  localparam logic [31:0] C_PS = 32'h00400040;
  localparam logic [31:0] C_RS = 32'h00700070;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd3;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqData = '0;
  logic [PW-1:0] pollLimit = '0;
  logic          busy, done, pass, timedOut, busWe, busRe;
  logic [AW-1:0] busAddr;
  logic [31:0]   busWdata;
  logic [31:0]   busRdata = '0;
  logic          busRvalid = 1'b0;

  flashOpSeq #(.ADDR_W(AW), .POLL_W(PW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .pollLimit(pollLimit),
    .busy(busy), .done(done), .pass(pass), .timedOut(timedOut),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata), .busRvalid(busRvalid)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // expected bus transactions
  typedef struct {
    bit            isWr;
    logic [AW-1:0] a;
    logic [31:0]   d;
    string         tag;
  } txn_t;
  txn_t expQ[$];

  task automatic expW(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    txn_t t; t.isWr = 1; t.a = a; t.d = d; t.tag = tag; expQ.push_back(t);
  endtask
  task automatic expR(input logic [AW-1:0] a, input string tag);
    txn_t t; t.isWr = 0; t.a = a; t.d = '0; t.tag = tag; expQ.push_back(t);
  endtask
  task automatic expPoll(input logic [AW-1:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      expW(a, C_RS, "R4");
      expR(a, "R4");
    end
  endtask

  // flash model knobs and state
  int          mNotReady = 0;
  logic [31:0] mHalfPat  = 32'h0;
  logic [31:0] mErr      = 32'h0;
  logic [31:0] mCorrupt  = 32'h0;
  logic [31:0] mMfr      = 32'h00890089;
  logic [31:0] mDev      = 32'h88F388F3;
  int          mode = 0;
  bit          pgmArm = 0, eraseArm = 0;
  int          pollsLeft = 0;
  logic [31:0] mem [int];
  bit          pend = 0, outst = 0;
  logic [31:0] pendData = '0;

  // monitor state
  bit expBusy = 0, doneLast = 0, doneSeen = 0, donePass = 0, doneTo = 0;

  task automatic modelWrite(input logic [AW-1:0] a, input logic [31:0] d);
    if (pgmArm) begin
      mem[int'(a)] = d ^ mCorrupt;
      pgmArm = 0; pollsLeft = mNotReady; mode = 1;
    end else begin
      case (d)
        C_PS: pgmArm = 1;
        C_ES: eraseArm = 1;
        C_EC: if (eraseArm) begin eraseArm = 0; pollsLeft = mNotReady; mode = 1; end
        C_RS: mode = 1;
        C_ID: mode = 2;
        C_RA: mode = 0;
        default: ;
      endcase
    end
  endtask

  task automatic modelRead(input logic [AW-1:0] a, output logic [31:0] v);
    if (mode == 1) begin
      if (pollsLeft > 0) begin pollsLeft--; v = mHalfPat; end
      else v = 32'h00800080 | mErr;
    end else if (mode == 2) begin
      v = (a == 0) ? mMfr : (a == 1) ? mDev : 32'h0;
    end else begin
      v = mem.exists(int'(a)) ? mem[int'(a)] : 32'hFFFFFFFF;
    end
  endtask

  // cycle monitor + flash model, all at the falling edge
  initial begin
    txn_t e;
    logic [31:0] v;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (busRvalid) begin busRvalid = 0; outst = 0; end
      if (pend) begin busRvalid = 1; busRdata = pendData; pend = 0; end
      if (doneLast) expBusy = 0;
      else if (!expBusy && reqValid && reqOp != 2'd3) expBusy = 1;
      check(busy == expBusy, "R10", "busy", 64'(busy), 64'(expBusy));
      doneLast = done;
      if (done) begin doneSeen = 1; donePass = pass; doneTo = timedOut; end
      if (busWe || busRe) begin
        check(!outst && !(busWe && busRe), "R11", "strobe overlap", 64'({busWe, busRe}), 64'(0));
        if (expQ.size() == 0) begin
          check(0, "R10", "unexpected strobe", 64'({busWe, busAddr}), 64'(0));
        end else begin
          e = expQ.pop_front();
          check(e.isWr == busWe && e.a == busAddr && (!e.isWr || e.d == busWdata),
                e.tag, "bus txn", {9'(busWe), busAddr, busWdata}, {9'(e.isWr), e.a, e.d});
        end
        if (busWe) modelWrite(busAddr, busWdata);
        else begin modelRead(busAddr, v); pendData = v; pend = 1; outst = 1; end
      end
    end
  end

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [PW-1:0] lim, input bit expPass, input bit expTo,
                       input string tag, input bit poke);
    int w;
    doneSeen = 0;
    @(negedge clk); #1;
    reqValid = 1; reqOp = op; reqAddr = a; reqData = d; pollLimit = lim;
    @(negedge clk); #1;
    reqValid = 0; reqAddr = '1; reqData = 32'hDEADBEEF; pollLimit = 16'd1;
    if (poke) begin
      repeat (3) @(negedge clk);
      #1 reqValid = 1; reqOp = 2'd0;
      @(negedge clk); #1 reqValid = 0;
    end
    w = 0;
    while (!doneSeen && w < 5000) begin @(negedge clk); w++; end
    check(doneSeen, "R10", "done seen", 64'(doneSeen), 64'(1));
    check(donePass == expPass, tag, "pass", 64'(donePass), 64'(expPass));
    check(doneTo == expTo, "R9", "timedOut", 64'(doneTo), 64'(expTo));
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5", "missing txns", 64'(expQ.size()), 64'(0));
    expQ.delete();
  endtask

  task automatic planProg(input logic [AW-1:0] a, input logic [31:0] d, input int polls, input bit to);
    expW(a, C_PS, "R2"); expW(a, d, "R2"); expPoll(a, polls);
    expW(a, C_RA, "R5");
    if (!to) expR(a, "R7");
  endtask
  task automatic planErase(input logic [AW-1:0] a, input int polls);
    expW(a, C_ES, "R3"); expW(a, C_EC, "R3"); expPoll(a, polls);
    expW(a, C_RA, "R5");
  endtask
  task automatic planIdent();
    expW('0, C_ID, "R8"); expR('0, "R8"); expR(AW'(1), "R8"); expW('0, C_RA, "R5");
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10", "watchdog", 64'(0), 64'(1));
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !busWe && !busRe, "R1", "reset outputs",
          64'({busy, done, busWe, busRe}), 64'(0));

    // program, two not-ready polls with one half ready (R2, R4, R7)
    mNotReady = 2; mHalfPat = 32'h00000080; mErr = 0; mCorrupt = 0;
    planProg(22'h001234, 32'hA5C30F17, 3, 0);
    runOp(2'd0, 22'h001234, 32'hA5C30F17, 16'd50, 1, 0, "R7", 0);

    // program error in upper half only (R7)
    mNotReady = 0; mErr = 32'h00100000;
    planProg(22'h002000, 32'h12345678, 1, 0);
    runOp(2'd0, 22'h002000, 32'h12345678, 16'd50, 0, 0, "R7", 0);

    // read-back mismatch with clean status (R7)
    mErr = 0; mCorrupt = 32'h00000100;
    planProg(22'h002004, 32'h0BADF00D, 1, 0);
    runOp(2'd0, 22'h002004, 32'h0BADF00D, 16'd50, 0, 0, "R7", 0);
    mCorrupt = 0;

    // erase, upper half ready first (R3, R4)
    mNotReady = 1; mHalfPat = 32'h00800000;
    planErase(22'h008000, 2);
    runOp(2'd1, 22'h008000, 32'h0, 16'd50, 1, 0, "R3", 0);

    // erase error in lower half (R6)
    mNotReady = 0; mErr = 32'h00000020;
    planErase(22'h010000, 1);
    runOp(2'd1, 22'h010000, 32'h0, 16'd50, 0, 0, "R6", 0);

    // program-error bits do not fail an erase (R6)
    mErr = 32'h00100010;
    planErase(22'h018000, 1);
    runOp(2'd1, 22'h018000, 32'h0, 16'd50, 1, 0, "R6", 0);
    mErr = 0;

    // identifier probes (R8)
    mMfr = 32'h00890089; mDev = 32'h88F388F3;
    planIdent(); runOp(2'd2, 22'h000777, 32'h0, 16'd50, 1, 0, "R8", 0);
    mDev = 32'h88F488F4;
    planIdent(); runOp(2'd2, 22'h000000, 32'h0, 16'd50, 1, 0, "R8", 0);
    mDev = 32'h88F188F1;
    planIdent(); runOp(2'd2, 22'h000000, 32'h0, 16'd50, 0, 0, "R8", 0);
    mMfr = 32'h00890088; mDev = 32'h88F388F3;
    planIdent(); runOp(2'd2, 22'h000000, 32'h0, 16'd50, 0, 0, "R8", 0);

    // timeouts (R9)
    mNotReady = 100000; mHalfPat = 32'h0;
    planProg(22'h003000, 32'h55AA55AA, 3, 1);
    runOp(2'd0, 22'h003000, 32'h55AA55AA, 16'd3, 0, 1, "R9", 0);
    planErase(22'h020000, 1);
    runOp(2'd1, 22'h020000, 32'h0, 16'd0, 0, 1, "R9", 0);

    // request while busy is ignored (R10)
    mNotReady = 4; mHalfPat = 32'h00000080;
    planErase(22'h028000, 5);
    runOp(2'd1, 22'h028000, 32'h0, 16'd50, 1, 0, "R10", 1);

    // opcode 3 never accepted (R10)
    @(negedge clk); #1 reqValid = 1; reqOp = 2'd3;
    @(negedge clk); #1 reqValid = 0;
    repeat (5) @(negedge clk);
    check(!busy, "R10", "op 3 ignored", 64'(busy), 64'(0));

    finishRun();
  end

endmodule